// File: doc/BRIEF.md
# Two-Address Banked Register Target for a Two-Wire Serial Bus

This block is a synthesizable target for a two-wire serial bus of the I2C kind. It gives a bus host read and write access to a configuration register space. SCL and SDA are oversampled with the fast system clock. The block detects start and stop conditions, shifts bytes in and out MSB first, and pulls SDA low to acknowledge. A second, combinational read port lets the core logic read any register.

One device answers on two bus addresses.

- **Main address.** This address is fixed except for one bit, which a strap input sets. It reaches one of three sub-maps. The sub-map is chosen by a bank field held in a control register.
- **Auxiliary address.** Software writes this address into a register. It reaches a fourth, separate map. It stays silent while that register holds zero.

The first byte written after the address byte sets a register pointer. Later bytes read or write consecutive registers. Reads and writes behave differently when the pointer runs past the last implemented register.

Top module: `i2cbk_target`

## Requirements
- R1: With `addr_sel` low the main address bytes are 0x40 (write) and 0x41 (read). With it high they are 0x42 and 0x43. An address byte that matches neither the main address nor an enabled auxiliary address gets a NACK, which means SDA is left high during the ninth clock.
- R2: Bit 0 of the address byte selects direction: 0 means the host writes and 1 means the host reads. Bits travel MSB first. An ACK is SDA held low during the ninth SCL high phase. The target changes its SDA drive only while SCL is low, except that it releases SDA on a start or a stop.
- R3: In a write transfer, the first byte after the address byte is the register pointer. Each following data byte is stored at the pointer, and the pointer then advances by one.
- R4: Bits [6:5] of register 0x0E choose the map that the main address reaches: 00 selects the user map (the reset value), 01 the interrupt map, 10 the second user map, and 11 also the user map. Register 0x0E can be read and written through the main address whichever bank is selected.
- R5: The core read port returns, in the same cycle, the register at `core_addr` of map `core_map` (0 user, 1 interrupt, 2 second user, 3 auxiliary). An address above `LAST_SUB` reads as 0.
- R6: The auxiliary address is bits [7:1] of user-map register 0xFD, which resets to 0x00. While that field is zero, nothing answers on the auxiliary address. Once 0x84 is written, the auxiliary map answers 0x84 for write and 0x85 for read.
- R7: A start seen after the second rising SCL edge of a byte, or during the ninth clock, sends the target to idle. A stop seen at any time sends it to idle and releases SDA. In idle, bytes get no ACK until the next start.
- R8: A register pointer above `LAST_SUB` (default 0xFD) gets a NACK. The target then goes idle, so the following bytes also get a NACK.
- R9: In a read, once the pointer reaches `LAST_SUB`, each further byte returns the register at `LAST_SUB`. This continues until the host NACKs.
- R10: In a write, a data byte whose pointer is above `LAST_SUB` is not stored. It gets a NACK, and the target goes idle.
- R11: A repeated start followed by a read address byte starts reading at the pointer set in the write phase before it.
- R12: In a read, the pointer advances only when the host ACKs a byte. A host NACK ends the transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Strap that sets bit 1 of the main address byte |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| core_map | input | 2 | Map selected by the core read port |
| core_addr | input | 8 | Register address for the core read port |
| core_rdata | output | 8 | Register value returned to the core logic |

## Verification
Transfers use both strap settings, with the bank field set to each of its four values. The auxiliary address is tried before and after it is programmed, which separates correct address decoding and bank routing from writes that land in the wrong map. Bursts that start just below the last register show the difference between the read and write overflow rules: a read keeps repeating the last register, while a write refuses the extra byte. Malformed traffic checks that the protocol state machine resynchronizes: a start or stop placed mid-byte, an out-of-range pointer, and a repeated start into a read.

// File: rtl/i2cbk_pkg.sv
package i2cbk_pkg;

    localparam int MAP_W    = 2;
    localparam int NUM_MAPS = 4;
    localparam int BYTE_W   = 8;
    localparam int PTR_W    = BYTE_W + 1;

    localparam logic [MAP_W-1:0] MAP_USER  = 2'd0;
    localparam logic [MAP_W-1:0] MAP_INTR  = 2'd1;
    localparam logic [MAP_W-1:0] MAP_USER2 = 2'd2;
    localparam logic [MAP_W-1:0] MAP_AUX   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              drv;
        logic              ackph;
        logic              nack;
        logic              rw;
        logic              aux;
        logic              hack;
        logic [PTR_W-1:0]  ptr;
    } tgt_regs_t;

endpackage

// File: rtl/i2cbk_line_sync.sv
module i2cbk_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_old;
        logic                   sda_old;
    } sync_regs_t;

    sync_regs_t q, d;

    logic scl_cur;
    logic sda_cur;

    assign scl_cur = q.scl_sh[SYNC_STAGES-1];
    assign sda_cur = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        d         = q;
        d.scl_sh  = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh  = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_old = scl_cur;
        d.sda_old = sda_cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl   = scl_cur;
    assign sda_lvl   = sda_cur;
    assign scl_rise  = scl_cur & ~q.scl_old;
    assign scl_fall  = ~scl_cur & q.scl_old;
    assign start_det = scl_cur & q.scl_old & q.sda_old & ~sda_cur;
    assign stop_det  = scl_cur & q.scl_old & ~q.sda_old & sda_cur;

endmodule

// File: rtl/i2cbk_reg_file.sv
module i2cbk_reg_file
    import i2cbk_pkg::*;
#(
    parameter logic [7:0] LAST_SUB      = 8'hFD,
    parameter logic [7:0] BANK_REG      = 8'h0E,
    parameter logic [7:0] AUX_ADDR_REG  = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MAP_W-1:0]  wr_map,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [MAP_W-1:0]  rd_map,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic [MAP_W-1:0]  core_map,
    input  logic [7:0]        core_addr,
    output logic [7:0]        core_rdata,
    output logic [1:0]        bank_sel,
    output logic [6:0]        aux_addr
);

    localparam int DEPTH = int'(LAST_SUB) + 1;

    logic [7:0] mem_q [NUM_MAPS][DEPTH];
    logic [7:0] ctrl_q;
    logic [7:0] ctrl_d;
    logic       ctrl_hit;

    assign ctrl_hit = wr_en && (wr_map != MAP_AUX) && (wr_addr == BANK_REG);

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_hit) begin
            ctrl_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem_q[m][i] <= '0;
                end
            end else if (wr_en && (wr_map == MAP_W'(m)) && !ctrl_hit) begin
                mem_q[m][wr_addr] <= wr_data;
            end
        end
    end

    always_comb begin
        if ((rd_map != MAP_AUX) && (rd_addr == BANK_REG)) begin
            rd_data = ctrl_q;
        end else begin
            rd_data = mem_q[rd_map][rd_addr];
        end
    end

    always_comb begin
        if (core_addr > LAST_SUB) begin
            core_rdata = '0;
        end else if ((core_map != MAP_AUX) && (core_addr == BANK_REG)) begin
            core_rdata = ctrl_q;
        end else begin
            core_rdata = mem_q[core_map][core_addr];
        end
    end

    assign bank_sel = ctrl_q[6:5];
    assign aux_addr = mem_q[MAP_USER][AUX_ADDR_REG][7:1];

endmodule

// File: rtl/i2cbk_target_fsm.sv
module i2cbk_target_fsm
    import i2cbk_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR7 = 7'h20,
    parameter logic [7:0] LAST_SUB   = 8'hFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [1:0]       bank_sel,
    input  logic [6:0]       aux_addr,
    input  logic [7:0]       rd_data,
    output logic [MAP_W-1:0] rd_map,
    output logic [7:0]       rd_addr,
    output logic             wr_en,
    output logic [MAP_W-1:0] wr_map,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_drive_low,
    output logic             busy,
    output logic             in_ack,
    output logic             rd_phase,
    output logic             aux_sel
);

    localparam logic [PTR_W-1:0] LAST_PTR = {1'b0, LAST_SUB};

    tgt_regs_t q, d;

    logic [6:0]       main7;
    logic             main_hit;
    logic             aux_hit;
    logic             ok;
    logic [MAP_W-1:0] cur_map;

    assign main7    = BASE_ADDR7 | {6'b0, addr_sel};
    assign main_hit = (q.sh[7:1] == main7);
    assign aux_hit  = (aux_addr != 7'd0) && (q.sh[7:1] == aux_addr);

    always_comb begin
        if (q.aux) begin
            cur_map = MAP_AUX;
        end else if (bank_sel == 2'b11) begin
            cur_map = MAP_USER;
        end else begin
            cur_map = bank_sel;
        end
    end

    always_comb begin
        d     = q;
        ok    = 1'b0;
        wr_en = 1'b0;
        if (stop_det) begin
            d.st    = ST_IDLE;
            d.drv   = 1'b0;
            d.ackph = 1'b0;
        end else if (start_det) begin
            d.drv   = 1'b0;
            d.ackph = 1'b0;
            d.cnt   = '0;
            d.nack  = 1'b0;
            if (q.st == ST_IDLE || (!q.ackph && q.cnt <= 4'd1)) begin
                d.st  = ST_ADDR;
                d.aux = 1'b0;
            end else begin
                d.st = ST_IDLE;
            end
        end else if (q.st != ST_IDLE) begin
            if (!q.ackph) begin
                if (q.st != ST_RDATA) begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.ackph = 1'b1;
                        case (q.st)
                            ST_ADDR: begin
                                ok    = main_hit || aux_hit;
                                d.rw  = q.sh[0];
                                d.aux = !main_hit && aux_hit;
                            end
                            ST_PTR: begin
                                ok = (q.sh <= LAST_SUB);
                                if (ok) begin
                                    d.ptr = {1'b0, q.sh};
                                end
                            end
                            default: begin
                                ok    = (q.ptr <= LAST_PTR);
                                wr_en = ok;
                                if (ok) begin
                                    d.ptr = q.ptr + 1'b1;
                                end
                            end
                        endcase
                        d.drv  = ok;
                        d.nack = !ok;
                    end
                end else begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.drv   = 1'b0;
                            d.ackph = 1'b1;
                        end else if (q.cnt != 4'd0) begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.drv = !q.sh[6];
                        end
                    end
                end
            end else begin
                if (q.st != ST_RDATA) begin
                    if (scl_fall) begin
                        d.ackph = 1'b0;
                        d.drv   = 1'b0;
                        d.cnt   = '0;
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            case (q.st)
                                ST_ADDR: begin
                                    if (q.rw) begin
                                        d.st  = ST_RDATA;
                                        d.sh  = rd_data;
                                        d.drv = !rd_data[7];
                                    end else begin
                                        d.st = ST_PTR;
                                    end
                                end
                                ST_PTR:  d.st = ST_WDATA;
                                default: d.st = q.st;
                            endcase
                        end
                    end
                end else begin
                    if (scl_rise) begin
                        d.hack = !sda_lvl;
                        if (!sda_lvl) begin
                            d.ptr = (q.ptr >= LAST_PTR) ? LAST_PTR : q.ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        d.ackph = 1'b0;
                        d.cnt   = '0;
                        if (q.hack) begin
                            d.sh  = rd_data;
                            d.drv = !rd_data[7];
                        end else begin
                            d.st  = ST_IDLE;
                            d.drv = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_map        = cur_map;
    assign rd_addr       = (q.ptr > LAST_PTR) ? LAST_SUB : q.ptr[7:0];
    assign wr_map        = cur_map;
    assign wr_addr       = q.ptr[7:0];
    assign wr_data       = q.sh;
    assign sda_drive_low = q.drv;
    assign busy          = (q.st != ST_IDLE);
    assign in_ack        = q.ackph;
    assign rd_phase      = (q.st == ST_RDATA);
    assign aux_sel       = q.aux;

endmodule

// File: rtl/i2cbk_target.sv
module i2cbk_target
    import i2cbk_pkg::*;
#(
    parameter int         SYNC_STAGES  = 2,
    parameter logic [6:0] BASE_ADDR7   = 7'h20,
    parameter logic [7:0] LAST_SUB     = 8'hFD,
    parameter logic [7:0] BANK_REG     = 8'h0E,
    parameter logic [7:0] AUX_ADDR_REG = 8'hFD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    input  logic [1:0] core_map,
    input  logic [7:0] core_addr,
    output logic [7:0] core_rdata
);

    logic             scl_lvl;
    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [1:0]       bank_sel;
    logic [6:0]       aux_addr;
    logic [7:0]       rd_data;
    logic [MAP_W-1:0] rd_map;
    logic [7:0]       rd_addr;
    logic             wr_en;
    logic [MAP_W-1:0] wr_map;
    logic [7:0]       wr_addr;
    logic [7:0]       wr_data;
    logic             busy;
    logic             in_ack;
    logic             rd_phase;
    logic             aux_sel;

    i2cbk_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cbk_target_fsm #(
        .BASE_ADDR7(BASE_ADDR7),
        .LAST_SUB  (LAST_SUB)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_sel      (addr_sel),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .bank_sel      (bank_sel),
        .aux_addr      (aux_addr),
        .rd_data       (rd_data),
        .rd_map        (rd_map),
        .rd_addr       (rd_addr),
        .wr_en         (wr_en),
        .wr_map        (wr_map),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .sda_drive_low (sda_drive_low),
        .busy          (busy),
        .in_ack        (in_ack),
        .rd_phase      (rd_phase),
        .aux_sel       (aux_sel)
    );

    i2cbk_reg_file #(
        .LAST_SUB    (LAST_SUB),
        .BANK_REG    (BANK_REG),
        .AUX_ADDR_REG(AUX_ADDR_REG)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_map     (wr_map),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_map     (rd_map),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .core_map   (core_map),
        .core_addr  (core_addr),
        .core_rdata (core_rdata),
        .bank_sel   (bank_sel),
        .aux_addr   (aux_addr)
    );

endmodule

// File: rtl/i2cbk_checker.sv
module i2cbk_checker #(
    parameter logic [7:0] LAST_SUB = 8'hFD
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_drive_low,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       busy,
    input logic       in_ack,
    input logic       rd_phase,
    input logic       aux_sel,
    input logic [6:0] aux_addr
);

    // R7: a stop always frees the data line
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R2: drive changes only while SCL is low, except on start or stop
    p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

    // R10: no store outside the implemented range
    p_write_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= LAST_SUB));

    // R3: a store is followed by the acknowledge phase
    p_write_then_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> in_ack);

    // R1: outside a read the target pulls SDA only to acknowledge
    p_ack_slot_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low && !rd_phase) |-> in_ack);

    // R6: the auxiliary map is never engaged while its address is zero
    p_aux_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && aux_sel) |-> (aux_addr != 7'd0));

endmodule

bind i2cbk_target i2cbk_checker #(.LAST_SUB(LAST_SUB)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_lvl       (scl_lvl),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .busy          (busy),
    .in_ack        (in_ack),
    .rd_phase      (rd_phase),
    .aux_sel       (aux_sel),
    .aux_addr      (aux_addr)
);

// File: tb/i2cbk_target_tb_top.sv
module i2cbk_target_tb_top;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_sel = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] core_map = '0;
    logic [7:0] core_addr = '0;
    logic       sda_drive_low;
    logic [7:0] core_rdata;
    logic       sda_line;

    assign sda_line = sda_h & ~sda_drive_low;

    always #5 clk = ~clk;

    i2cbk_target dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_sel      (addr_sel),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .core_map      (core_map),
        .core_addr     (core_addr),
        .core_rdata    (core_rdata)
    );

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 0;

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: result %h with nothing expected", obs_val);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (obs_val !== it.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, obs_val, it.val);
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        exp_t it;
        it.req = req;
        it.val = exp;
        exp_q.push_back(it);
        obs_val = act;
        -> obs_ev;
        @(negedge clk);
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_h = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        sda_h = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bstop();
        sda_h = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        sda_h = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b;  wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        b = sda_line; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic wr_byte(input logic [7:0] v, input logic exp_nack, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        check(req, {7'b0, a}, {7'b0, exp_nack});
    endtask

    task automatic rd_byte(input logic [7:0] exp, input logic host_nack, input string req);
        logic [7:0] v;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(host_nack);
        check(req, v, exp);
    endtask

    task automatic core_chk(input logic [1:0] m, input logic [7:0] a, input logic [7:0] exp,
                            input string req);
        core_map = m;
        core_addr = a;
        @(negedge clk);
        check(req, core_rdata, exp);
    endtask

    task automatic reg_write(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] v,
                             input string req);
        bstart();
        wr_byte(dev, 1'b0, req);
        wr_byte(a, 1'b0, req);
        wr_byte(v, 1'b0, req);
        bstop();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        core_chk(2'd0, 8'hFD, 8'h00, "R6 aux address register reset");
        core_chk(2'd0, 8'h0E, 8'h00, "R4 bank register reset");
        check("R2 SDA released after reset", {7'b0, sda_drive_low}, 8'h00);

        // R1 R3: burst write on main address
        bstart();
        wr_byte(8'h40, 1'b0, "R1 main write address");
        wr_byte(8'h10, 1'b0, "R3 pointer byte");
        wr_byte(8'hA5, 1'b0, "R3 first data");
        wr_byte(8'h3C, 1'b0, "R3 second data");
        bstop();
        core_chk(2'd0, 8'h10, 8'hA5, "R3 R5 stored at pointer");
        core_chk(2'd0, 8'h11, 8'h3C, "R3 R5 stored at pointer plus one");

        // R1: other strap address ignored
        bstart();
        wr_byte(8'h42, 1'b1, "R1 wrong strap address");
        bstop();

        // R11 R12: repeated start into read
        bstart();
        wr_byte(8'h40, 1'b0, "R11 address");
        wr_byte(8'h10, 1'b0, "R11 pointer");
        bstart();
        wr_byte(8'h41, 1'b0, "R2 read direction address");
        rd_byte(8'hA5, 1'b0, "R11 read from written pointer");
        rd_byte(8'h3C, 1'b1, "R12 read after host ack");
        bstop();
        check("R12 SDA released after host NACK", {7'b0, sda_drive_low}, 8'h00);

        // R4: bank switching
        reg_write(8'h40, 8'h0E, 8'h20, "R4 select interrupt map");
        reg_write(8'h40, 8'h10, 8'h77, "R4 write in interrupt map");
        core_chk(2'd1, 8'h10, 8'h77, "R4 interrupt map written");
        core_chk(2'd0, 8'h10, 8'hA5, "R4 user map untouched");
        bstart();
        wr_byte(8'h40, 1'b0, "R4 address");
        wr_byte(8'h0E, 1'b0, "R4 pointer to bank register");
        bstart();
        wr_byte(8'h41, 1'b0, "R4 read address");
        rd_byte(8'h20, 1'b1, "R4 bank register visible in interrupt map");
        bstop();
        reg_write(8'h40, 8'h0E, 8'h40, "R4 select second user map");
        reg_write(8'h40, 8'h10, 8'h88, "R4 write in second user map");
        core_chk(2'd2, 8'h10, 8'h88, "R4 second user map written");
        reg_write(8'h40, 8'h0E, 8'h60, "R4 reserved bank value");
        reg_write(8'h40, 8'h10, 8'h5A, "R4 write with bank 11");
        core_chk(2'd0, 8'h10, 8'h5A, "R4 bank 11 reaches user map");
        reg_write(8'h40, 8'h0E, 8'h00, "R4 back to user map");

        // R6: auxiliary address
        bstart();
        wr_byte(8'h84, 1'b1, "R6 aux address silent before programming");
        bstop();
        reg_write(8'h40, 8'hFD, 8'h84, "R6 program aux address");
        reg_write(8'h84, 8'h05, 8'h99, "R6 write through aux address");
        core_chk(2'd3, 8'h05, 8'h99, "R6 R5 aux map written");
        core_chk(2'd0, 8'h05, 8'h00, "R6 user map untouched");
        bstart();
        wr_byte(8'h84, 1'b0, "R6 aux address");
        wr_byte(8'h05, 1'b0, "R6 pointer");
        bstart();
        wr_byte(8'h85, 1'b0, "R6 aux read address");
        rd_byte(8'h99, 1'b1, "R6 aux read data");
        bstop();

        // R8: nonexistent pointer
        bstart();
        wr_byte(8'h40, 1'b0, "R8 address");
        wr_byte(8'hFE, 1'b1, "R8 pointer out of range");
        wr_byte(8'h12, 1'b1, "R8 idle after bad pointer");
        bstop();
        core_chk(2'd0, 8'hFE, 8'h00, "R5 core read above range");

        // R10: write overflow in second user map
        reg_write(8'h40, 8'h0E, 8'h40, "R10 select second user map");
        bstart();
        wr_byte(8'h40, 1'b0, "R10 address");
        wr_byte(8'hFC, 1'b0, "R10 pointer");
        wr_byte(8'h11, 1'b0, "R10 data at FC");
        wr_byte(8'h22, 1'b0, "R10 data at FD");
        wr_byte(8'h33, 1'b1, "R10 data beyond end");
        wr_byte(8'h44, 1'b1, "R10 idle after overflow");
        bstop();
        core_chk(2'd2, 8'hFC, 8'h11, "R10 FC kept");
        core_chk(2'd2, 8'hFD, 8'h22, "R10 last register not overwritten");

        // R9: read overflow
        bstart();
        wr_byte(8'h40, 1'b0, "R9 address");
        wr_byte(8'hFC, 1'b0, "R9 pointer");
        bstart();
        wr_byte(8'h41, 1'b0, "R9 read address");
        rd_byte(8'h11, 1'b0, "R9 byte at FC");
        rd_byte(8'h22, 1'b0, "R9 byte at FD");
        rd_byte(8'h22, 1'b0, "R9 repeat of last register");
        rd_byte(8'h22, 1'b1, "R9 repeat until host NACK");
        bstop();

        // R7: start in the middle of a byte
        bstart();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bstart();
        wr_byte(8'h40, 1'b1, "R7 idle after mid-byte start");
        bstop();
        // R7: stop in the middle of a data byte
        bstart();
        wr_byte(8'h40, 1'b0, "R7 address");
        wr_byte(8'h20, 1'b0, "R7 pointer");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bstop();
        check("R7 SDA released after stop", {7'b0, sda_drive_low}, 8'h00);
        core_chk(2'd2, 8'h20, 8'h00, "R7 partial byte not stored");
        bstart();
        wr_byte(8'h40, 1'b0, "R7 next transfer accepted");
        bstop();

        // R1: strap high
        addr_sel = 1'b1;
        bstart();
        wr_byte(8'h42, 1'b0, "R1 strap high address");
        wr_byte(8'h0E, 1'b0, "R1 pointer");
        bstart();
        wr_byte(8'h43, 1'b0, "R1 strap high read address");
        rd_byte(8'h40, 1'b1, "R2 read bank register");
        bstop();
        bstart();
        wr_byte(8'h40, 1'b1, "R1 low-strap address rejected");
        bstop();

        repeat (10) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule